// File: doc/BRIEF.md
# Chained Three-Operand Cipher ALU

This execution unit evaluates one instruction built from two operations applied back to back over three source operands, producing a single 32-bit result. The first operation acts on operands 1 and 2. The second operation acts on that intermediate value and operand 3. Each operation is either a cheap logical step (exclusive-or, and, increment, sign-extend, pass) or a mid-cost arithmetic step (add, subtract, rotate left, rotate right, pass). Either step may be the arithmetic one, so patterns that cipher rounds repeat, such as an add followed by an exclusive-or, need one instruction rather than two.

The unit checks each pairing before it commits a result. When both steps are arithmetic, or when a code outside the supported set appears, it flags the instruction as illegal and does not write the destination. A small control state machine with the states IDLE, DONE and FAULT sequences the output side. The transitions are: from any state, an accepted legal instruction goes to DONE; an accepted illegal instruction goes to FAULT; a cycle with no instruction goes to IDLE. The result register, the destination index and the flags appear one cycle after the instruction is presented.

Top module: `fused_alu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, out_illegal and out_wr_en are 0, and out_result is 0.
- R2: An instruction sampled with in_valid high at a rising edge is reported with out_valid high for the cycle that follows that edge. out_valid is low after any edge at which in_valid was low.
- R3: Operation codes are 4 bits: 0 pass, 1 xor, 2 and, 3 increment, 4 sign-extend, 5 add, 6 subtract, 7 rotate left, 8 rotate right. The first step (in_op_a) combines operand 1 with operand 2, and the second step (in_op_b) combines the intermediate value with operand 3. Unary steps use only their first input, and pass returns its first input unchanged.
- R4: Increment adds 1 with wraparound. Sign-extend copies bit 7 of its input into bits 31 to 8 and keeps bits 7 to 0. Xor and and act bitwise.
- R5: Add and subtract (first input minus second input) wrap modulo 2^32.
- R6: Rotates use only the low 5 bits of their second input as the amount. The upper bits have no effect.
- R7: The fused forms work with the arithmetic step in either position, for example (op1+op2) xor op3, (op1 and op2) rotated left by op3, (op1 and op2) xor op3, and (op1 rotated by op2) xor op3.
- R8: A pairing is illegal when both codes lie in 5 to 8, or when either code is 9 to 15. An illegal instruction gives out_valid=1, out_illegal=1 and out_wr_en=0, and leaves out_result holding its previous value.
- R9: out_dest carries the in_dest value of the reported instruction. out_wr_en is 1 exactly when a legal instruction is reported.
- R10: One instruction may be accepted every cycle. Back-to-back instructions each produce their own result in consecutive cycles.
- R11: out_result changes only in the cycle after a legal instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| in_op_a | input | 4 | Code of the first step |
| in_op_b | input | 4 | Code of the second step |
| in_src1 | input | 32 | Operand 1 |
| in_src2 | input | 32 | Operand 2 |
| in_src3 | input | 32 | Operand 3 |
| in_dest | input | 5 | Destination register index |
| out_valid | output | 1 | A result or fault is being reported |
| out_illegal | output | 1 | The reported instruction had an illegal pairing |
| out_wr_en | output | 1 | Destination write enable |
| out_dest | output | 5 | Destination register index of the reported instruction |
| out_result | output | 32 | Registered result |

## Verification
The bench builds the unit with its default 32-bit width, 5-bit destination index and sign bit at position 7. It uses these values because the 4-bit code space is small. All 256 pairs of first and second codes are swept over several operand triples. This reaches every legal chain, every illegal pairing and every reserved code. Rotate amounts of 0, 31 and values with upper bits set are included. The sweep runs back to back, so the behaviour of one instruction right after another, and of a fault right after a write, is checked against the held result.

// File: rtl/fused_alu_pkg.sv
package fused_alu_pkg;

    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_XOR  = 4'd1,
        OP_AND  = 4'd2,
        OP_INC  = 4'd3,
        OP_SEXT = 4'd4,
        OP_ADD  = 4'd5,
        OP_SUB  = 4'd6,
        OP_ROL  = 4'd7,
        OP_ROR  = 4'd8
    } step_op_e;

    localparam int unsigned LAST_CODE = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } ctrl_state_e;

    function automatic logic is_arith(input logic [3:0] code);
        return (code >= 4'(OP_ADD)) && (code <= 4'(OP_ROR));
    endfunction

    function automatic logic is_known(input logic [3:0] code);
        return code <= 4'(LAST_CODE);
    endfunction

endpackage

// File: rtl/fused_pair_check.sv
module fused_pair_check
    import fused_alu_pkg::*;
(
    input  logic [3:0] code_a,
    input  logic [3:0] code_b,
    output logic       legal
);
    logic both_arith;
    logic any_unknown;

    always_comb begin
        both_arith  = is_arith(code_a) && is_arith(code_b);
        any_unknown = !is_known(code_a) || !is_known(code_b);
        legal       = !both_arith && !any_unknown;
    end
endmodule

// File: rtl/fused_step.sv
module fused_step
    import fused_alu_pkg::*;
#(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned SIGN_BIT = 7
) (
    input  logic [3:0]       code,
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic [WIDTH-1:0] res
);
    localparam int unsigned AMT_W = $clog2(WIDTH);
    localparam int unsigned HIGH_W = WIDTH - SIGN_BIT - 1;

    logic [AMT_W-1:0]   amount;
    logic [2*WIDTH-1:0] left_dbl;
    logic [2*WIDTH-1:0] right_dbl;
    logic [WIDTH-1:0]   sext_val;

    always_comb begin
        amount    = rhs[AMT_W-1:0];
        left_dbl  = {lhs, lhs} << amount;
        right_dbl = {lhs, lhs} >> amount;
        sext_val  = {{HIGH_W{lhs[SIGN_BIT]}}, lhs[SIGN_BIT:0]};
    end

    always_comb begin
        unique case (step_op_e'(code))
            OP_PASS: res = lhs;
            OP_XOR:  res = lhs ^ rhs;
            OP_AND:  res = lhs & rhs;
            OP_INC:  res = lhs + WIDTH'(1);
            OP_SEXT: res = sext_val;
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_ROL:  res = left_dbl[2*WIDTH-1:WIDTH];
            OP_ROR:  res = right_dbl[WIDTH-1:0];
            default: res = lhs;
        endcase
    end
endmodule

// File: rtl/fused_ctrl.sv
module fused_ctrl
    import fused_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic legal,
    output logic report,
    output logic fault,
    output logic commit
);
    ctrl_state_e state_q;
    ctrl_state_e state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (accept) begin
            state_d = legal ? ST_DONE : ST_FAULT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        report = 1'b0;
        fault  = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DONE:  begin report = 1'b1; commit = 1'b1; end
            ST_FAULT: begin report = 1'b1; fault  = 1'b1; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/fused_alu.sv
module fused_alu
    import fused_alu_pkg::*;
#(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned DEST_W   = 5,
    parameter int unsigned SIGN_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op_a,
    input  logic [3:0]        in_op_b,
    input  logic [WIDTH-1:0]  in_src1,
    input  logic [WIDTH-1:0]  in_src2,
    input  logic [WIDTH-1:0]  in_src3,
    input  logic [DEST_W-1:0] in_dest,
    output logic              out_valid,
    output logic              out_illegal,
    output logic              out_wr_en,
    output logic [DEST_W-1:0] out_dest,
    output logic [WIDTH-1:0]  out_result
);
    logic             pair_ok;
    logic [WIDTH-1:0] mid_val;
    logic [WIDTH-1:0] fin_val;
    logic [WIDTH-1:0] result_q;
    logic [DEST_W-1:0] dest_q;

    fused_pair_check u_check (
        .code_a (in_op_a),
        .code_b (in_op_b),
        .legal  (pair_ok)
    );

    fused_step #(.WIDTH(WIDTH), .SIGN_BIT(SIGN_BIT)) u_first (
        .code (in_op_a),
        .lhs  (in_src1),
        .rhs  (in_src2),
        .res  (mid_val)
    );

    fused_step #(.WIDTH(WIDTH), .SIGN_BIT(SIGN_BIT)) u_second (
        .code (in_op_b),
        .lhs  (mid_val),
        .rhs  (in_src3),
        .res  (fin_val)
    );

    fused_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (in_valid),
        .legal  (pair_ok),
        .report (out_valid),
        .fault  (out_illegal),
        .commit (out_wr_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            dest_q   <= '0;
        end else if (in_valid) begin
            dest_q <= in_dest;
            if (pair_ok) begin
                result_q <= fin_val;
            end
        end
    end

    assign out_result = result_q;
    assign out_dest   = dest_q;
endmodule

// File: rtl/fused_alu_chk.sv
module fused_alu_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_illegal,
    input logic             out_wr_en,
    input logic [WIDTH-1:0] out_result
);
    // R1
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!out_valid && !out_illegal && !out_wr_en && out_result == '0);
        end
    end

    // R2
    accept_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_valid && !out_wr_en));

    // R8
    fault_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> $stable(out_result));

    // R9
    write_needs_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_wr_en != out_illegal));

    // R11
    idle_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
endmodule

bind fused_alu fused_alu_chk #(.WIDTH(WIDTH)) u_fused_alu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_wr_en   (out_wr_en),
    .out_result  (out_result)
);

// File: tb/tb_fused_alu.sv
module tb_fused_alu;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    in_op_a = '0;
    logic [3:0]    in_op_b = '0;
    logic [W-1:0]  in_src1 = '0;
    logic [W-1:0]  in_src2 = '0;
    logic [W-1:0]  in_src3 = '0;
    logic [4:0]    in_dest = '0;
    logic          out_valid;
    logic          out_illegal;
    logic          out_wr_en;
    logic [4:0]    out_dest;
    logic [W-1:0]  out_result;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] held = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fused_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_op_a(in_op_a), .in_op_b(in_op_b),
        .in_src1(in_src1), .in_src2(in_src2), .in_src3(in_src3),
        .in_dest(in_dest), .out_valid(out_valid), .out_illegal(out_illegal),
        .out_wr_en(out_wr_en), .out_dest(out_dest), .out_result(out_result)
    );

    function automatic logic [W-1:0] model_step(input logic [3:0] c,
                                                input logic [W-1:0] a,
                                                input logic [W-1:0] b);
        logic [W-1:0] v;
        v = a;
        case (c)
            4'd1: v = a ^ b;
            4'd2: v = a & b;
            4'd3: v = a + 1;
            4'd4: v = a[7] ? (a | 32'hFFFF_FF00) : (a & 32'h0000_00FF);
            4'd5: v = a + b;
            4'd6: v = a + ~b + 1;
            4'd7: for (int k = 0; k < int'(b % 32); k++) v = {v[W-2:0], v[W-1]};
            4'd8: for (int k = 0; k < int'(b % 32); k++) v = {v[0], v[W-1:1]};
            default: v = a;
        endcase
        return v;
    endfunction

    function automatic logic model_legal(input logic [3:0] ca, input logic [3:0] cb);
        if (ca > 4'd8 || cb > 4'd8) return 1'b0;
        if (ca >= 4'd5 && cb >= 4'd5) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string tag, input logic [W+7:0] got, input logic [W+7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; issues one instruction and checks it one cycle later.
    task automatic issue(input string tag, input logic [3:0] ca, input logic [3:0] cb,
                         input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic [W-1:0] z, input logic [4:0] d);
        logic ok;
        logic [W-1:0] exp_res;
        ok = model_legal(ca, cb);
        exp_res = ok ? model_step(cb, model_step(ca, x, y), z) : held;
        in_valid = 1'b1; in_op_a = ca; in_op_b = cb;
        in_src1 = x; in_src2 = y; in_src3 = z; in_dest = d;
        @(negedge clk);
        check(tag, {out_valid, out_illegal, out_wr_en, out_dest, out_result},
              {1'b1, !ok, ok, d, exp_res});
        held = exp_res;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] ops [4][3];
        ops[0] = '{32'h1234_5678, 32'h0F0F_00A5, 32'hDEAD_BEEF};
        ops[1] = '{32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000};
        ops[2] = '{32'h0000_0080, 32'hFFFF_FFE0, 32'h0000_007F};
        ops[3] = '{32'hA5A5_5A5A, 32'h0000_003F, 32'h1357_9BDF};

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, out_illegal, out_wr_en, out_dest, out_result}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_illegal, out_wr_en, out_dest, out_result}, '0);

        // R4 tiny steps
        issue("R4", 4'd3, 4'd0, 32'hFFFF_FFFF, 0, 0, 5'd1);
        check("R4", out_result, 32'h0);
        issue("R4", 4'd4, 4'd0, 32'h1234_5681, 0, 0, 5'd2);
        check("R4", out_result, 32'hFFFF_FF81);
        issue("R4", 4'd4, 4'd0, 32'hFFFF_FF7F, 0, 0, 5'd3);
        check("R4", out_result, 32'h0000_007F);
        // R5 wrap
        issue("R5", 4'd5, 4'd0, 32'hFFFF_FFF0, 32'h20, 0, 5'd4);
        check("R5", out_result, 32'h10);
        issue("R5", 4'd6, 4'd0, 32'h5, 32'h7, 0, 5'd5);
        check("R5", out_result, 32'hFFFF_FFFE);
        // R6 rotate amount from low 5 bits only
        issue("R6", 4'd7, 4'd0, 32'h8000_0001, 32'hFFFF_FFE1, 0, 5'd6);
        check("R6", out_result, 32'h0000_0003);
        issue("R6", 4'd8, 4'd0, 32'h8000_0001, 32'h0000_0020, 0, 5'd7);
        check("R6", out_result, 32'h8000_0001);
        issue("R6", 4'd8, 4'd0, 32'h0000_0001, 32'h0000_001F, 0, 5'd8);
        check("R6", out_result, 32'h0000_0002);
        // R7 fused forms, both orders
        issue("R7", 4'd5, 4'd1, 32'h1, 32'h2, 32'hF, 5'd9);
        check("R7", out_result, 32'hC);
        issue("R7", 4'd2, 4'd7, 32'hF000_000F, 32'h8000_00FF, 32'h4, 5'd10);
        check("R7", out_result, 32'h0000_00F8);
        issue("R7", 4'd2, 4'd1, 32'hFF00, 32'h0FF0, 32'h0101, 5'd11);
        check("R7", out_result, 32'h0E01);
        issue("R7", 4'd7, 4'd1, 32'h0000_0001, 32'h8, 32'h0000_0101, 5'd12);
        check("R7", out_result, 32'h0000_0001);
        // R8 illegal keeps previous value
        issue("R8", 4'd5, 4'd6, 32'h1, 32'h1, 32'h1, 5'd13);
        check("R8", out_result, 32'h0000_0001);
        issue("R8", 4'd9, 4'd0, 32'h1, 32'h1, 32'h1, 5'd14);
        check("R8", out_result, 32'h0000_0001);

        // R3 R8 R9 R10: back-to-back sweep of every code pair
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    issue(model_legal(4'(a), 4'(b)) ? "R3" : "R8", 4'(a), 4'(b),
                          ops[s][0], ops[s][1], ops[s][2], 5'(a + b + s));
                end
            end
        end

        // R2 R11: idle cycles report nothing and keep the result
        in_valid = 1'b0;
        in_src1 = 32'h5555_5555;
        @(negedge clk);
        check("R2", {7'd0, out_valid, out_result}, {7'd0, 1'b0, held});
        @(negedge clk);
        check("R11", {7'd0, out_illegal, out_result}, {7'd0, 1'b0, held});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule